// File: doc/BRIEF.md
# Quad DAC serial register front end

This block is the digital control side of a four-channel digital-to-analog converter. A host writes frames over a three-wire serial link made of an active-low chip select, a serial clock and a data line. Every frame carries a two-bit command header, a two-bit channel address and a data word. It becomes either a data write to one channel, a shutdown of one channel, or a shutdown of all four. Each channel keeps an input register and a DAC register. A level-sensitive, active-low load input moves the input registers into the DAC registers.

The serial lines and the load line are asynchronous to the system clock. They are resynchronised through two flip-flop stages before any edge is detected. The data width is a parameter. The frame is always four header bits wider than the data word, so a 12-bit part takes 16-bit frames and a 10-bit part takes 14-bit frames. Each channel drives its DAC register word to its output while it is active, drives zero while it is shut down, and raises a shutdown indicator.

Top module: `qdac_frontend`

## Requirements
- R1: After reset every input register, DAC register, output word and shutdown indicator is zero.
- R2: Frame bits are taken MSB first; the frame is, from the top, SA, SD, A1, A0 and then DATA_W data bits. When chip select rises with SA=0 and SD=0, the data goes into the input register of the channel given by A1:A0 (0 = A, 1 = B, 2 = C, 3 = D). The other channels keep their input registers.
- R3: Serial clock edges while chip select is high do not change the shift register.
- R4: A frame with SA=1 shuts down all four channels, whatever SD and the address hold.
- R5: A frame with SA=0, SD=1 shuts down only the addressed channel and leaves every input register unchanged.
- R6: While load is low, every DAC register takes the value of its input register within a few system clocks.
- R7: While load is high, the DAC registers hold, even when input registers are written.
- R8: A shut-down channel outputs a zero word, but its DAC register is still loaded. The stored value appears at the output once the channel leaves shutdown.
- R9: A data write to a channel clears that channel's shutdown.
- R10: Only the last FRAME_W bits shifted during one chip-select-low period are decoded. A frame with fewer bits is decoded from whatever the shift register holds, including bits left over from earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; bits are taken on its rising edge |
| cs_n_i | input | 1 | Active-low chip select; its rising edge ends a frame |
| sdi_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Level-sensitive load; low makes the DAC registers follow the input registers |
| dac_word_o | output | 4*DATA_W | Channel output words, channel A in the lowest DATA_W bits; zero while a channel is shut down |
| shdn_o | output | 4 | Shutdown indicators, bit 0 for channel A |

## Verification
The bench builds the block at its default of 12 data bits, which gives the 16-bit frame. At that width all four address codes can be used, as can over-long frames of 20 bits and short frames of a few bits. Random data words cover the whole 12-bit range, including all-zero and all-one words. The 10-bit variant differs only in the width parameter, since every header and data position is derived from DATA_W.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH   = 4;
    localparam int HDR_W    = 4;
    localparam int ADDR_W   = 2;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'd0,
        CMD_WRITE    = 2'd1,
        CMD_SHDN_ONE = 2'd2,
        CMD_SHDN_ALL = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [ADDR_W-1:0]  ch;
    } cmd_t;

    // Header nibble: {SA, SD, A1, A0}
    function automatic cmd_t decode_header(input logic [HDR_W-1:0] hdr);
        cmd_t c;
        c.ch = hdr[ADDR_W-1:0];
        if (hdr[3])
            c.kind = CMD_SHDN_ALL;
        else if (hdr[2])
            c.kind = CMD_SHDN_ONE;
        else
            c.kind = CMD_WRITE;
        return c;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] sr_o
);
    logic [FRAME_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (shift_en_i)
            sr_q <= {sr_q[FRAME_W-2:0], bit_i};
    end

    assign sr_o = sr_q;
endmodule

// File: rtl/qdac_decoder.sv
module qdac_decoder
    import qdac_pkg::*;
#(
    parameter int DATA_W  = 12,
    localparam int FRAME_W = DATA_W + HDR_W
) (
    input  logic               fire_i,
    input  logic [FRAME_W-1:0] sr_i,
    output cmd_t               cmd_o,
    output logic [DATA_W-1:0]  data_o
);
    cmd_t hdr_cmd;

    always_comb begin
        hdr_cmd = decode_header(sr_i[FRAME_W-1 -: HDR_W]);
        cmd_o   = hdr_cmd;
        if (!fire_i)
            cmd_o.kind = CMD_NONE;
    end

    assign data_o = sr_i[DATA_W-1:0];
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
    import qdac_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_ID  = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              load_n_i,
    output logic [DATA_W-1:0] inp_o,
    output logic [DATA_W-1:0] dac_o,
    output logic [DATA_W-1:0] word_o,
    output logic              shdn_o
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CH_ID);

    logic [DATA_W-1:0] inp_q;
    logic [DATA_W-1:0] dac_q;
    logic              shdn_q;
    logic              hit;
    logic              do_write;
    logic              do_shdn;

    assign hit      = (cmd_i.ch == MY_ADDR);
    assign do_write = (cmd_i.kind == CMD_WRITE) && hit;
    assign do_shdn  = (cmd_i.kind == CMD_SHDN_ALL) ||
                      ((cmd_i.kind == CMD_SHDN_ONE) && hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            inp_q  <= '0;
            dac_q  <= '0;
            shdn_q <= 1'b0;
        end else begin
            if (do_write) begin
                inp_q  <= data_i;
                shdn_q <= 1'b0;
            end
            if (do_shdn)
                shdn_q <= 1'b1;
            if (!load_n_i)
                dac_q <= inp_q;
        end
    end

    assign inp_o  = inp_q;
    assign dac_o  = dac_q;
    assign shdn_o = shdn_q;
    assign word_o = shdn_q ? '0 : dac_q;
endmodule

// File: rtl/qdac_frontend.sv
module qdac_frontend
    import qdac_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int FRAME_W = DATA_W + HDR_W,
    localparam int BUS_W   = NUM_CH * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    input  logic              load_n_i,
    output logic [BUS_W-1:0]  dac_word_o,
    output logic [NUM_CH-1:0] shdn_o
);
    // synchronised bundle: {load_n, cs_n, sdi, sclk}
    logic [3:0] raw_in;
    logic [3:0] syn;
    logic       sclk_s, sdi_s, cs_s, load_s;
    logic       sclk_d, cs_d;
    logic       sclk_rise, cs_rise;
    logic [FRAME_W-1:0] sr;
    cmd_t               cmd;
    logic [DATA_W-1:0]  data;
    logic [BUS_W-1:0]   inp_flat;
    logic [BUS_W-1:0]   dac_flat;

    assign raw_in = {load_n_i, cs_n_i, sdi_i, sclk_i};

    qdac_sync #(.W(4), .RST_VAL(4'b1100)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn)
    );

    assign sclk_s = syn[0];
    assign sdi_s  = syn[1];
    assign cs_s   = syn[2];
    assign load_s = syn[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = cs_s & ~cs_d;

    qdac_shifter #(.FRAME_W(FRAME_W)) shift_i (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (sclk_rise & ~cs_s),
        .bit_i      (sdi_s),
        .sr_o       (sr)
    );

    qdac_decoder #(.DATA_W(DATA_W)) dec_i (
        .fire_i (cs_rise),
        .sr_i   (sr),
        .cmd_o  (cmd),
        .data_o (data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qdac_channel #(.DATA_W(DATA_W), .CH_ID(c)) ch_i (
            .clk      (clk),
            .rst      (rst),
            .cmd_i    (cmd),
            .data_i   (data),
            .load_n_i (load_s),
            .inp_o    (inp_flat[c*DATA_W +: DATA_W]),
            .dac_o    (dac_flat[c*DATA_W +: DATA_W]),
            .word_o   (dac_word_o[c*DATA_W +: DATA_W]),
            .shdn_o   (shdn_o[c])
        );
    end
endmodule

// File: rtl/qdac_frontend_chk.sv
module qdac_frontend_chk #(
    parameter int DATA_W  = 12,
    parameter int FRAME_W = 16,
    parameter int BUS_W   = 48
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_s,
    input logic               load_s,
    input logic               cs_rise,
    input logic [FRAME_W-1:0] sr,
    input logic [BUS_W-1:0]   inp_flat,
    input logic [BUS_W-1:0]   dac_flat,
    input logic [3:0]         shdn_o
);
    assert_hold_sr_R3: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> $stable(sr));

    assert_all_down_R4: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && sr[FRAME_W-1]) |=> (shdn_o == 4'hF));

    assert_follow_R6: assert property (@(posedge clk) disable iff (rst)
        !load_s |=> (dac_flat == $past(inp_flat)));

    assert_hold_dac_R7: assert property (@(posedge clk) disable iff (rst)
        load_s |=> $stable(dac_flat));

    assert_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !sr[FRAME_W-1] && !sr[FRAME_W-2])
        |=> !shdn_o[$past(sr[FRAME_W-3 -: 2])]);

    assert_one_down_R5: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !sr[FRAME_W-1] && sr[FRAME_W-2]) |=> $stable(inp_flat));
endmodule

bind qdac_frontend qdac_frontend_chk #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .BUS_W  (BUS_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .load_s   (load_s),
    .cs_rise  (cs_rise),
    .sr       (sr),
    .inp_flat (inp_flat),
    .dac_flat (dac_flat),
    .shdn_o   (shdn_o)
);

// File: tb/qdac_frontend_tb_top.sv
module qdac_frontend_tb_top;
    localparam int DW = 12;
    localparam int FW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic load_n = 1'b1;
    logic [4*DW-1:0] word;
    logic [3:0] shdn;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_inp [4];
    logic [DW-1:0] m_dac [4];
    logic          m_sd  [4];
    logic [FW-1:0] m_sr;
    logic          m_load_n;

    always #4 clk = ~clk;

    qdac_frontend #(.DATA_W(DW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .sdi_i      (sdi),
        .load_n_i   (load_n),
        .dac_word_o (word),
        .shdn_o     (shdn)
    );

    function automatic logic [DW-1:0] exp_word(input int c);
        return m_sd[c] ? '0 : m_dac[c];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_inp[c] = '0; m_dac[c] = '0; m_sd[c] = 1'b0;
        end
        m_sr = '0;
        m_load_n = 1'b1;
    endtask

    task automatic model_follow();
        if (!m_load_n)
            for (int c = 0; c < 4; c++) m_dac[c] = m_inp[c];
    endtask

    task automatic model_decode();
        int a;
        a = int'(m_sr[FW-3 -: 2]);
        if (m_sr[FW-1]) begin
            for (int c = 0; c < 4; c++) m_sd[c] = 1'b1;
        end else if (m_sr[FW-2]) begin
            m_sd[a] = 1'b1;
        end else begin
            m_inp[a] = m_sr[DW-1:0];
            m_sd[a]  = 1'b0;
        end
        model_follow();
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            n_checks++;
            if (word[c*DW +: DW] !== exp_word(c)) begin
                n_errors++;
                $display("FAIL %s ch%0d word: actual=%h expected=%h",
                         tag, c, word[c*DW +: DW], exp_word(c));
            end
        end
        n_checks++;
        if (shdn !== {m_sd[3], m_sd[2], m_sd[1], m_sd[0]}) begin
            n_errors++;
            $display("FAIL %s shutdown: actual=%b expected=%b", tag, shdn,
                     {m_sd[3], m_sd[2], m_sd[1], m_sd[0]});
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        sdi = b;
        wait_clk(3);
        sclk = 1'b1;
        wait_clk(3);
        sclk = 1'b0;
    endtask

    // shifts n bits of 'bits' MSB first in one chip-select window
    task automatic send_bits(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wait_clk(3);
        for (int i = n - 1; i >= 0; i--) begin
            pulse_bit(bits[i]);
            m_sr = {m_sr[FW-2:0], bits[i]};
        end
        wait_clk(3);
        cs_n = 1'b1;
        wait_clk(10);
        model_decode();
    endtask

    task automatic send_frame(input logic sa, input logic sd, input logic [1:0] a,
                              input logic [DW-1:0] d);
        send_bits({16'h0, sa, sd, a, d}, FW);
    endtask

    task automatic set_load(input logic v);
        load_n = v;
        m_load_n = v;
        wait_clk(8);
        model_follow();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        int seed;
        seed = 7;
        v = DW'($urandom(seed));
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        check_all("R1 reset");

        // R2 and R6: write each channel with load low
        set_load(1'b0);
        send_frame(1'b0, 1'b0, 2'd0, 12'h123);
        send_frame(1'b0, 1'b0, 2'd1, 12'hABC);
        send_frame(1'b0, 1'b0, 2'd2, 12'h000);
        send_frame(1'b0, 1'b0, 2'd3, 12'hFFF);
        check_all("R2/R6 address map");

        // R3: clocks with chip select high carry ones; an empty frame
        // then decodes the untouched shift register (write D again)
        sdi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_clk(3); sclk = 1'b1; wait_clk(3); sclk = 1'b0;
        end
        send_bits(32'h0, 0);
        check_all("R3 clock ignored with cs high");

        // R7: hold while load high
        set_load(1'b1);
        send_frame(1'b0, 1'b0, 2'd0, 12'h5A5);
        check_all("R7 hold");
        set_load(1'b0);
        check_all("R6 release");

        // R5: single shutdown of C
        send_frame(1'b0, 1'b1, 2'd2, 12'h777);
        check_all("R5 single shutdown");

        // R4: SA with other fields set still hits all
        send_frame(1'b1, 1'b0, 2'd1, 12'h3C3);
        check_all("R4 all shutdown");

        // R9: write wakes only A
        send_frame(1'b0, 1'b0, 2'd0, 12'h0F0);
        check_all("R9 wake by write");

        // R8: load while B shut down, then wake B
        set_load(1'b1);
        send_frame(1'b0, 1'b0, 2'd1, 12'h456);
        send_frame(1'b0, 1'b1, 2'd1, 12'h000);
        set_load(1'b0);
        check_all("R8 loaded during shutdown");
        send_frame(1'b0, 1'b0, 2'd1, 12'h456);
        check_all("R8 value after wake");

        // R10: over-long frame, junk ones first
        send_bits({12'h0, 4'hF, 4'b0011, 12'h9E1}, 20);
        check_all("R10 long frame");
        // R10: short frame of 4 bits reuses older bits
        send_bits(32'h0000_0005, 4);
        check_all("R10 short frame");

        // random mix
        for (int it = 0; it < 150; it++) begin
            int r;
            logic sa, sd;
            r = int'($urandom_range(0, 9));
            sa = (r == 0);
            sd = (r == 1) || (r == 2);
            send_frame(sa, sd, 2'($urandom_range(0, 3)), DW'($urandom));
            if ($urandom_range(0, 3) == 0)
                set_load(~m_load_n);
            check_all("R2/R4/R5/R6/R7/R9 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule